// File: doc/BRIEF.md
# CCD Pixel Region Tagger

This block runs beside a full-frame CCD readout sequencer. On every cycle where the sample strobe is high, it reads the sequencer's line and pixel counters and sorts the sampled position into one of four regions: horizontal-register dummy, light-shielded dark reference, active image, or overclock. It reports the region code one cycle later. For active pixels it also raises a valid flag and gives zero-based image coordinates.

The block also watches a digitized video input. It sums the samples taken at dark-reference positions across the whole frame. Dark-reference positions are the leading shielded columns of every line, plus all non-dummy columns of the fully dark lines at the top and bottom of the frame. The running sum clears on the first pixel of a frame. When the last pixel of a frame is sampled, the block divides the sum by the number of dark samples taken. It then publishes the average with a one-cycle valid pulse. Every boundary is a parameter.

The default geometry is as follows:
- A line has 3103 pixel counts: 14 leading dummy pixels, 20 dark pixels, 3056 active pixels, 10 overclock pixels and 3 trailing dummy pixels.
- A frame has 3086 lines: 20 dark lines, 3056 active lines, 1 overclock line and 9 dark lines.

Top module: `ccd_region_tagger`

## Requirements
- R1: While reset is held and right after it, regionValid, actValid and darkValid are low and darkAvg is zero.
- R2: The first LEAD_DUMMY and the last TRAIL_DUMMY pixel positions of every line get region code 2'b00 and never add to the dark sum.
- R3: On every line, the LEAD_DARK positions right after the leading dummy pixels get region code 2'b01 and add to the dark sum.
- R4: On the first TOP_DARK lines and the last BOT_DARK lines of a frame, every position that is not a dummy position gets code 2'b01 and adds to the dark sum.
- R5: A position in the active window gets code 2'b10, actValid high, actX equal to pixel index minus (LEAD_DUMMY+LEAD_DARK), and actY equal to line index minus TOP_DARK. The active window is ACTIVE_W columns starting at LEAD_DUMMY+LEAD_DARK, and ACTIVE_H lines starting at TOP_DARK.
- R6: Every other position in the frame (overclock columns and lines) gets code 2'b00 with actValid low. Code 2'b11 never appears.
- R7: The tag outputs register the strobe cycle's result one clock later, and regionValid follows the strobe. A cycle with the strobe low produces regionValid and actValid low, and its video, line and pixel values have no effect on the dark sum.
- R8: A strobed sample at line 0, pixel 0 clears the dark sum and count, so each published average covers one frame only.
- R9: A strobed sample at the last line and last pixel ends the frame. Within SUM_W+3 cycles, darkAvg shows floor(sum/count) of that frame's dark samples, and darkValid is high for exactly one cycle. darkAvg holds its value until the next publication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | High when the current counters and video describe a sampled pixel |
| lineIdx | input | LINE_W | Line counter from the sequencer, 0 at frame top |
| pixIdx | input | PIX_W | Pixel counter within the line, 0 at line start |
| video | input | DATA_W | Digitized video sample |
| regionCode | output | 2 | 00 dummy or overclock, 01 dark, 10 active |
| regionValid | output | 1 | Region code describes the previous cycle's strobe |
| actValid | output | 1 | Previous sample was an active pixel |
| actX | output | PIX_W | Active-window column of that pixel |
| actY | output | LINE_W | Active-window row of that pixel |
| darkAvg | output | DATA_W | Dark level of the last completed frame |
| darkValid | output | 1 | One-cycle pulse when darkAvg is updated |

## Verification
The bench fills dummy positions with full-scale video. A design that let dummy pixels into the dark sum would publish an average that is far too high. Idle cycles with the strobe low carry full-scale video and point at a dark position. Accumulating them would raise the count and shift the average, and a tag leaking through would show regionValid high. Two frames with different video patterns run back to back, so a sum that failed to clear at frame start would give a doubled result. Every position is checked for its code and coordinates. This catches off-by-one boundaries at the dark-line edges, the overclock line and the overclock columns. A wrong divider or a stretched valid pulse shows up as a wrong value or a second high cycle on darkValid.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

  typedef enum logic [1:0] {
    REG_NONE   = 2'b00,
    REG_DARK   = 2'b01,
    REG_ACTIVE = 2'b10
  } regionCode_e;

  // strobes from the decode/sequence control to the datapath
  typedef struct packed {
    logic       sample;
    logic [1:0] region;
    logic       active;
    logic       clearAcc;
    logic       addDark;
    logic       divLoad;
    logic       divStep;
    logic       divFinish;
  } tagCtl_t;

endpackage

// File: rtl/ccd_tag_ctrl.sv
module ccd_tag_ctrl
  import ccd_tag_pkg::*;
#(
  parameter int LINE_PIXELS = 3103,
  parameter int FRAME_LINES = 3086,
  parameter int LEAD_DUMMY  = 14,
  parameter int LEAD_DARK   = 20,
  parameter int TRAIL_DUMMY = 3,
  parameter int TOP_DARK    = 20,
  parameter int BOT_DARK    = 9,
  parameter int ACTIVE_W    = 3056,
  parameter int ACTIVE_H    = 3056,
  parameter int PIX_W       = 12,
  parameter int LINE_W      = 12,
  parameter int SUM_W       = 34,
  parameter int SHIFT_SEL   = -1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [PIX_W-1:0]  pixIdx,
  output tagCtl_t           ctl
);

  localparam logic [31:0] DUMMY_END  = 32'(LEAD_DUMMY);
  localparam logic [31:0] DARK_END   = 32'(LEAD_DUMMY + LEAD_DARK);
  localparam logic [31:0] TRAIL_BEG  = 32'(LINE_PIXELS - TRAIL_DUMMY);
  localparam logic [31:0] ACT_X_END  = 32'(LEAD_DUMMY + LEAD_DARK + ACTIVE_W);
  localparam logic [31:0] ACT_Y_BEG  = 32'(TOP_DARK);
  localparam logic [31:0] ACT_Y_END  = 32'(TOP_DARK + ACTIVE_H);
  localparam logic [31:0] BOT_BEG    = 32'(FRAME_LINES - BOT_DARK);
  localparam logic [31:0] LAST_LINE  = 32'(FRAME_LINES - 1);
  localparam logic [31:0] LAST_PIX   = 32'(LINE_PIXELS - 1);
  localparam logic [31:0] NUM_LINES  = 32'(FRAME_LINES);
  localparam int          ITER_W     = $clog2(SUM_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_DONE} divState_e;

  logic [31:0] px, ln;
  logic        dummyCol, darkLine, leadDarkCol, inWindow, inFrame;
  logic        firstPix, lastPix;
  logic [1:0]  region;
  divState_e   state;
  logic [ITER_W-1:0] iter;

  assign px = 32'(pixIdx);
  assign ln = 32'(lineIdx);

  always_comb begin
    dummyCol    = (px < DUMMY_END) || (px >= TRAIL_BEG);
    darkLine    = (ln < ACT_Y_BEG) || (ln >= BOT_BEG);
    leadDarkCol = (px >= DUMMY_END) && (px < DARK_END);
    inWindow    = (px >= DARK_END) && (px < ACT_X_END) &&
                  (ln >= ACT_Y_BEG) && (ln < ACT_Y_END);
    inFrame     = ln < NUM_LINES;
    firstPix    = (ln == 32'd0) && (px == 32'd0);
    lastPix     = (ln == LAST_LINE) && (px == LAST_PIX);
    if (!inFrame || dummyCol)        region = REG_NONE;
    else if (darkLine || leadDarkCol) region = REG_DARK;
    else if (inWindow)               region = REG_ACTIVE;
    else                             region = REG_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      iter  <= '0;
    end else if (sampleStb && lastPix) begin
      state <= S_LOAD;
    end else begin
      case (state)
        S_LOAD: begin
          if (SHIFT_SEL >= 0) state <= S_DONE;
          else begin
            state <= S_RUN;
            iter  <= ITER_W'(SUM_W - 1);
          end
        end
        S_RUN: begin
          if (iter == '0) state <= S_DONE;
          else            iter  <= iter - 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.sample    = sampleStb;
    ctl.region    = sampleStb ? region : REG_NONE;
    ctl.active    = sampleStb && (region == REG_ACTIVE);
    ctl.clearAcc  = sampleStb && firstPix;
    ctl.addDark   = sampleStb && (region == REG_DARK);
    ctl.divLoad   = state == S_LOAD;
    ctl.divStep   = state == S_RUN;
    ctl.divFinish = state == S_DONE;
  end

endmodule

// File: rtl/ccd_tag_dp.sv
module ccd_tag_dp
  import ccd_tag_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PIX_W     = 12,
  parameter int LINE_W    = 12,
  parameter int CNT_W     = 18,
  parameter int SUM_W     = 34,
  parameter int ACT_X0    = 34,
  parameter int ACT_Y0    = 20,
  parameter int SHIFT_SEL = -1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagCtl_t           ctl,
  input  logic [DATA_W-1:0] video,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [PIX_W-1:0]  pixIdx,
  output logic [1:0]        regionCode,
  output logic              regionValid,
  output logic              actValid,
  output logic [PIX_W-1:0]  actX,
  output logic [LINE_W-1:0] actY,
  output logic [DATA_W-1:0] darkAvg,
  output logic              darkValid
);

  logic [SUM_W-1:0] darkSum;
  logic [CNT_W-1:0] darkCnt;
  logic [SUM_W-1:0] quot;

  // tag outputs and dark accumulation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionCode  <= '0;
      regionValid <= 1'b0;
      actValid    <= 1'b0;
      actX        <= '0;
      actY        <= '0;
      darkSum     <= '0;
      darkCnt     <= '0;
    end else begin
      regionValid <= ctl.sample;
      regionCode  <= ctl.region;
      actValid    <= ctl.active;
      if (ctl.active) begin
        actX <= pixIdx - PIX_W'(ACT_X0);
        actY <= lineIdx - LINE_W'(ACT_Y0);
      end
      if (ctl.clearAcc) begin
        darkSum <= ctl.addDark ? SUM_W'(video) : '0;
        darkCnt <= ctl.addDark ? CNT_W'(1) : '0;
      end else if (ctl.addDark) begin
        darkSum <= darkSum + SUM_W'(video);
        darkCnt <= darkCnt + 1'b1;
      end
    end
  end

  generate
    if (SHIFT_SEL >= 0) begin : g_shift
      logic [SUM_W-1:0] shifted;
      always_ff @(posedge clk) begin
        if (!rstN)            shifted <= '0;
        else if (ctl.divLoad) shifted <= darkSum >> SHIFT_SEL;
      end
      assign quot = shifted;
    end else begin : g_div
      logic [SUM_W-1:0] quo;
      logic [SUM_W-1:0] rem;
      logic [CNT_W-1:0] divisor;
      logic [SUM_W:0]   remShift;
      logic [SUM_W:0]   divWide;
      assign remShift = {rem, quo[SUM_W-1]};
      assign divWide  = (SUM_W + 1)'(divisor);
      always_ff @(posedge clk) begin
        if (!rstN) begin
          quo     <= '0;
          rem     <= '0;
          divisor <= '0;
        end else if (ctl.divLoad) begin
          quo     <= darkSum;
          rem     <= '0;
          divisor <= darkCnt;
        end else if (ctl.divStep) begin
          if (remShift >= divWide) begin
            rem <= SUM_W'(remShift - divWide);
            quo <= {quo[SUM_W-2:0], 1'b1};
          end else begin
            rem <= SUM_W'(remShift);
            quo <= {quo[SUM_W-2:0], 1'b0};
          end
        end
      end
      assign quot = (divisor == '0) ? '0 : quo;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      darkAvg   <= '0;
      darkValid <= 1'b0;
    end else begin
      darkValid <= ctl.divFinish;
      if (ctl.divFinish)
        darkAvg <= (|quot[SUM_W-1:DATA_W]) ? '1 : quot[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
  import ccd_tag_pkg::*;
#(
  parameter int LINE_PIXELS = 3103,
  parameter int FRAME_LINES = 3086,
  parameter int LEAD_DUMMY  = 14,
  parameter int LEAD_DARK   = 20,
  parameter int TRAIL_DUMMY = 3,
  parameter int TOP_DARK    = 20,
  parameter int BOT_DARK    = 9,
  parameter int ACTIVE_W    = 3056,
  parameter int ACTIVE_H    = 3056,
  parameter int DATA_W      = 16,
  localparam int PIX_W      = $clog2(LINE_PIXELS),
  localparam int LINE_W     = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [PIX_W-1:0]  pixIdx,
  input  logic [DATA_W-1:0] video,
  output logic [1:0]        regionCode,
  output logic              regionValid,
  output logic              actValid,
  output logic [PIX_W-1:0]  actX,
  output logic [LINE_W-1:0] actY,
  output logic [DATA_W-1:0] darkAvg,
  output logic              darkValid
);

  localparam int NON_DUMMY = LINE_PIXELS - LEAD_DUMMY - TRAIL_DUMMY;
  localparam int DARK_ROWS = TOP_DARK + BOT_DARK;
  localparam int DARK_MAX  = DARK_ROWS * NON_DUMMY + (FRAME_LINES - DARK_ROWS) * LEAD_DARK;
  localparam int CNT_W     = $clog2(DARK_MAX + 1);
  localparam int SUM_W     = DATA_W + CNT_W;
  localparam int SHIFT_SEL = ((DARK_MAX & (DARK_MAX - 1)) == 0) ? $clog2(DARK_MAX) : -1;

  tagCtl_t ctl;

  ccd_tag_ctrl #(
    .LINE_PIXELS(LINE_PIXELS), .FRAME_LINES(FRAME_LINES),
    .LEAD_DUMMY(LEAD_DUMMY), .LEAD_DARK(LEAD_DARK), .TRAIL_DUMMY(TRAIL_DUMMY),
    .TOP_DARK(TOP_DARK), .BOT_DARK(BOT_DARK),
    .ACTIVE_W(ACTIVE_W), .ACTIVE_H(ACTIVE_H),
    .PIX_W(PIX_W), .LINE_W(LINE_W), .SUM_W(SUM_W), .SHIFT_SEL(SHIFT_SEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
    .lineIdx(lineIdx), .pixIdx(pixIdx), .ctl(ctl)
  );

  ccd_tag_dp #(
    .DATA_W(DATA_W), .PIX_W(PIX_W), .LINE_W(LINE_W),
    .CNT_W(CNT_W), .SUM_W(SUM_W),
    .ACT_X0(LEAD_DUMMY + LEAD_DARK), .ACT_Y0(TOP_DARK), .SHIFT_SEL(SHIFT_SEL)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .video(video),
    .lineIdx(lineIdx), .pixIdx(pixIdx),
    .regionCode(regionCode), .regionValid(regionValid),
    .actValid(actValid), .actX(actX), .actY(actY),
    .darkAvg(darkAvg), .darkValid(darkValid)
  );

endmodule

// File: rtl/ccd_region_tagger_chk.sv
module ccd_region_tagger_chk #(
  parameter int LEAD_DUMMY = 14,
  parameter int PIX_W      = 12,
  parameter int DATA_W     = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStb,
  input logic [PIX_W-1:0]  pixIdx,
  input logic              regionValid,
  input logic [1:0]        regionCode,
  input logic              actValid,
  input logic              darkValid,
  input logic [DATA_W-1:0] darkAvg
);

  localparam logic [31:0] LEAD_LIM = 32'(LEAD_DUMMY);

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !regionValid && !actValid && !darkValid); // R1
  AST_LEAD_DUMMY: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && (32'(pixIdx) < LEAD_LIM)) |=> (regionCode == 2'b00) && !actValid); // R2
  AST_ACT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    actValid |-> (regionCode == 2'b10) && regionValid); // R5
  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    regionCode != 2'b11); // R6
  AST_STB_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> regionValid); // R7
  AST_NO_STB_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> !regionValid && !actValid); // R7
  AST_DARK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    darkValid |=> !darkValid); // R9
  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !darkValid |-> $stable(darkAvg)); // R9

endmodule

bind ccd_region_tagger ccd_region_tagger_chk #(
  .LEAD_DUMMY(LEAD_DUMMY), .PIX_W(PIX_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .pixIdx(pixIdx),
  .regionValid(regionValid), .regionCode(regionCode), .actValid(actValid),
  .darkValid(darkValid), .darkAvg(darkAvg)
);

// File: tb/ccd_region_tagger_test.sv
module ccd_region_tagger_test;

  localparam int PERIOD = 10;
  localparam int LP = 12, FL = 10, LDU = 2, LDK = 3, TDU = 1;
  localparam int TOPD = 2, BOTD = 1, AW = 5, AH = 6, DW = 8;
  localparam int PW = $clog2(LP), LW = $clog2(FL);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleStb = 1'b0;
  logic [LW-1:0] lineIdx = '0;
  logic [PW-1:0] pixIdx = '0;
  logic [DW-1:0] video = '0;
  logic [1:0]    regionCode;
  logic          regionValid, actValid, darkValid;
  logic [PW-1:0] actX;
  logic [LW-1:0] actY;
  logic [DW-1:0] darkAvg;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD/2) clk = ~clk;

  ccd_region_tagger #(
    .LINE_PIXELS(LP), .FRAME_LINES(FL), .LEAD_DUMMY(LDU), .LEAD_DARK(LDK),
    .TRAIL_DUMMY(TDU), .TOP_DARK(TOPD), .BOT_DARK(BOTD),
    .ACTIVE_W(AW), .ACTIVE_H(AH), .DATA_W(DW)
  ) uut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lineIdx(lineIdx),
    .pixIdx(pixIdx), .video(video), .regionCode(regionCode),
    .regionValid(regionValid), .actValid(actValid), .actX(actX), .actY(actY),
    .darkAvg(darkAvg), .darkValid(darkValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected category from the requirements: 0 dummy, 1 dark line, 2 lead dark, 3 active, 4 overclock
  function automatic int category(input int ln, input int px);
    if (px < LDU || px >= LP - TDU) return 0;
    if (ln < TOPD || ln >= FL - BOTD) return 1;
    if (px < LDU + LDK) return 2;
    if (ln < TOPD + AH && px < LDU + LDK + AW) return 3;
    return 4;
  endfunction

  function automatic int codeOf(input int cat);
    case (cat)
      1, 2:    return 1;
      3:       return 2;
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(input int cat);
    case (cat)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic testReset();
    check(regionValid == 1'b0, "R1 regionValid", int'(regionValid), 0);
    check(actValid == 1'b0, "R1 actValid", int'(actValid), 0);
    check(darkValid == 1'b0, "R1 darkValid", int'(darkValid), 0);
    check(darkAvg == '0, "R1 darkAvg", int'(darkAvg), 0);
  endtask

  // scans one full frame; optionally inserts strobe-low cycles carrying bait values
  task automatic scanFrame(input int seed, input bit gaps);
    int expSum = 0;
    int expCnt = 0;
    int waitCnt = 0;
    int expAvg;
    for (int ln = 0; ln < FL; ln++) begin
      for (int px = 0; px < LP; px++) begin
        int cat = category(ln, px);
        if (gaps && ((ln + px) % 5 == 0)) begin
          sampleStb = 1'b0;
          lineIdx   = LW'(0);
          pixIdx    = PW'(LDU);
          video     = '1;
          @(negedge clk);
          check(!regionValid && !actValid, "R7 idle cycle tagged",
                int'({regionValid, actValid}), 0);
        end
        sampleStb = 1'b1;
        lineIdx   = LW'(ln);
        pixIdx    = PW'(px);
        video     = (cat == 0) ? 8'hFF : DW'((seed + ln * 7 + px * 3) % 200);
        if (codeOf(cat) == 1) begin
          expSum += int'(video);
          expCnt++;
        end
        @(negedge clk);
        check(regionValid && regionCode == 2'(codeOf(cat)), reqOf(cat),
              int'(regionCode), codeOf(cat));
        check(actValid == (cat == 3), {reqOf(cat), " actValid"}, int'(actValid), int'(cat == 3));
        if (cat == 3)
          check(actX == PW'(px - LDU - LDK) && actY == LW'(ln - TOPD), "R5 coords",
                int'({actY, actX}), ((ln - TOPD) << PW) | (px - LDU - LDK));
      end
    end
    sampleStb = 1'b0;
    video     = '1;
    expAvg = expSum / expCnt;
    while (!darkValid && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
    end
    check(darkValid == 1'b1, "R9 darkValid seen", int'(darkValid), 1);
    check(waitCnt <= 17, "R9 latency", waitCnt, 17);
    check(darkAvg == DW'(expAvg), "R8 R9 dark average", int'(darkAvg), expAvg);
    @(negedge clk);
    check(darkValid == 1'b0, "R9 single pulse", int'(darkValid), 0);
    repeat (3) @(negedge clk);
    check(darkAvg == DW'(expAvg), "R9 average held", int'(darkAvg), expAvg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    scanFrame(11, 1'b0);
    scanFrame(90, 1'b1);
    scanFrame(3, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule